// File: doc/BRIEF.md
# Cross-Clock Mailbox Register

This block carries one 36-bit word from a writer running on one clock to a reader running on a second, unrelated clock, without going through the FIFO storage. An active-low mail flag goes low when the writer deposits a word and returns high when the reader takes it. While the word is outstanding, the writer cannot replace it.

Each side keeps a single toggle bit. The writer flips its bit when it accepts a word. The reader flips its own bit when it consumes the word. Each bit reaches the opposite domain through a multi-flop synchronizer. The mail flag is low whenever the two bits differ. Because each side acts only on the other side's synchronized bit, every event arrives, though late, and the two bits never move in the same handshake phase. The reader's data output is a multiplexer: with mailbox select high it shows the stored word, and with mailbox select low it shows the FIFO output register that feeds it.

Top module: `xclk_mailbox`

## Requirements
- R1: The block stores one 36-bit word, taken from `wr_data` on a writer-clock rising edge with `wr_en` high while the mailbox is free. The reader sees that word on `rd_data` when `rd_sel_mbx` is high.
- R2: A writer-clock rising edge that accepts a word drives `mail_n` low right after that edge.
- R3: While the writer has not yet seen the reader's clear, further writes are ignored, and the stored word and `mail_n` do not change.
- R4: A reader-clock rising edge with `rd_en` high and `rd_sel_mbx` high, once the word is visible to the reader (synchronized), returns `mail_n` high right after that edge. A read with `rd_sel_mbx` low, an edge with `rd_en` low, or a read on the first or second reader edge after the write does not change `mail_n`.
- R5: Reset (synchronous, active high, held across several edges of both clocks) leaves `mail_n` high and the stored word all zeros.
- R6: `rd_data` equals the stored word when `rd_sel_mbx` is 1 and equals `fifo_q` when `rd_sel_mbx` is 0, combinationally.
- R7: The stored word stays stable from its write until the reader's clear. After a clear, a held write request is accepted no later than the third writer-clock rising edge after the clearing reader edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Writer-domain clock |
| rd_clk | input | 1 | Reader-domain clock |
| rst | input | 1 | Synchronous active-high reset, applied in both domains |
| wr_en | input | 1 | Mailbox write strobe, writer domain |
| wr_data | input | 36 | Word to deposit |
| rd_en | input | 1 | Read strobe, reader domain |
| rd_sel_mbx | input | 1 | 1 selects the mailbox, 0 selects the FIFO output |
| fifo_q | input | 36 | FIFO output register contents |
| rd_data | output | 36 | Reader-side data output |
| mail_n | output | 1 | Low while a word is waiting |

## Verification
If one side's toggle bit is wrong, the fault appears on `mail_n`. The flag either fails to fall on the write edge or stays low after the clearing read edge, and the bench checks it right after each of those edges. If the writer ignores its blocked state, the overwrite attempt changes `rd_data` while mail is pending. If the synchronizer depth is too short or too long, early reads start clearing the flag, or a held write is no longer accepted within three writer edges. Each of these shows up in the first iteration that hits the case, and the sweep runs through many words with varied bit patterns under two asynchronous clock phases.

// File: rtl/xclk_mailbox_pkg.sv
package xclk_mailbox_pkg;

    localparam int unsigned MBX_W = 36;

    typedef logic [MBX_W-1:0] mbx_word_t;

    typedef struct packed {
        logic      en;
        mbx_word_t data;
    } mbx_wr_req_t;

    function automatic logic toggles_differ(input logic a, input logic b);
        return a ^ b;
    endfunction

endpackage

// File: rtl/xclk_mailbox_sync.sv
module xclk_mailbox_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= 1'b0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/xclk_mailbox_wr.sv
module xclk_mailbox_wr
    import xclk_mailbox_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  mbx_wr_req_t req,
    input  logic        clr_tgl_async,
    output logic        set_tgl,
    output mbx_word_t   word_q
);
    logic clr_seen;
    logic busy;
    logic accept;

    xclk_mailbox_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
        .clk    (clk),
        .rst    (rst),
        .d_async(clr_tgl_async),
        .q      (clr_seen)
    );

    assign busy   = toggles_differ(set_tgl, clr_seen);
    assign accept = req.en && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            set_tgl <= 1'b0;
            word_q  <= '0;
        end else if (accept) begin
            set_tgl <= ~set_tgl;
            word_q  <= req.data;
        end
    end

    p_hold_word_r3: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(word_q));

    p_set_leaves_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (set_tgl != $past(set_tgl)) |-> busy);
endmodule

// File: rtl/xclk_mailbox_rd.sv
module xclk_mailbox_rd
    import xclk_mailbox_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      rd_en,
    input  logic      rd_sel_mbx,
    input  logic      set_tgl_async,
    input  mbx_word_t word_async,
    input  mbx_word_t fifo_q,
    output logic      clr_tgl,
    output mbx_word_t rd_data
);
    logic set_seen;
    logic pending;

    xclk_mailbox_sync #(.STAGES(SYNC_STAGES)) u_set_sync (
        .clk    (clk),
        .rst    (rst),
        .d_async(set_tgl_async),
        .q      (set_seen)
    );

    assign pending = toggles_differ(set_seen, clr_tgl);

    always_ff @(posedge clk) begin
        if (rst)                               clr_tgl <= 1'b0;
        else if (rd_en && rd_sel_mbx && pending) clr_tgl <= ~clr_tgl;
    end

    assign rd_data = rd_sel_mbx ? word_async : fifo_q;

    p_clear_needs_mail_r4: assert property (@(posedge clk) disable iff (rst)
        (clr_tgl != $past(clr_tgl)) |-> $past(pending));

    p_idle_no_clear_r4: assert property (@(posedge clk) disable iff (rst)
        !pending |=> $stable(clr_tgl));

    p_word_steady_r7: assert property (@(posedge clk) disable iff (rst)
        (pending && $past(pending)) |-> $stable(word_async));
endmodule

// File: rtl/xclk_mailbox.sv
module xclk_mailbox
    import xclk_mailbox_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [MBX_W-1:0]  wr_data,
    input  logic              rd_en,
    input  logic              rd_sel_mbx,
    input  logic [MBX_W-1:0]  fifo_q,
    output logic [MBX_W-1:0]  rd_data,
    output logic              mail_n
);
    mbx_wr_req_t req;
    mbx_word_t   word_q;
    logic        set_tgl;
    logic        clr_tgl;

    assign req.en   = wr_en;
    assign req.data = wr_data;

    xclk_mailbox_wr #(.SYNC_STAGES(SYNC_STAGES)) u_wr (
        .clk          (wr_clk),
        .rst          (rst),
        .req          (req),
        .clr_tgl_async(clr_tgl),
        .set_tgl      (set_tgl),
        .word_q       (word_q)
    );

    xclk_mailbox_rd #(.SYNC_STAGES(SYNC_STAGES)) u_rd (
        .clk          (rd_clk),
        .rst          (rst),
        .rd_en        (rd_en),
        .rd_sel_mbx   (rd_sel_mbx),
        .set_tgl_async(set_tgl),
        .word_async   (word_q),
        .fifo_q       (fifo_q),
        .clr_tgl      (clr_tgl),
        .rd_data      (rd_data)
    );

    // The two toggles never flip in the same handshake phase, so this XOR is glitch-free.
    assign mail_n = ~toggles_differ(set_tgl, clr_tgl);
endmodule

// File: tb/xclk_mailbox_test.sv
`timescale 1ns/1ps
module xclk_mailbox_test;
    localparam int W = 36;

    logic         wr_clk = 1'b0;
    logic         rd_clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         rd_en = 1'b0;
    logic         rd_sel_mbx = 1'b0;
    logic [W-1:0] fifo_q = '0;
    logic [W-1:0] rd_data;
    logic         mail_n;

    int checks = 0;
    int fails  = 0;

    xclk_mailbox uut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst),
        .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_sel_mbx(rd_sel_mbx), .fifo_q(fifo_q),
        .rd_data(rd_data), .mail_n(mail_n)
    );

    always #10 wr_clk = ~wr_clk;
    initial begin
        #3;
        forever begin
            rd_clk = 1'b1; #7;
            rd_clk = 1'b0; #7;
        end
    end

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    task automatic rd_pulse(input logic en, input logic sel, input int edges);
        @(negedge rd_clk);
        rd_en = en; rd_sel_mbx = sel;
        repeat (edges) @(posedge rd_clk);
        #1 rd_en = 1'b0;
    endtask

    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [W-1:0] word;
        int n;
        repeat (6) @(posedge wr_clk);
        @(negedge wr_clk) rst = 1'b0;
        #1;
        check("R5 flag after reset", {35'd0, mail_n}, 36'd1);
        rd_sel_mbx = 1'b1; #1;
        check("R5 word after reset", rd_data, '0);
        fifo_q = 36'h5_A5A5_A5A5; rd_sel_mbx = 1'b0; #1;
        check("R6 fifo path", rd_data, 36'h5_A5A5_A5A5);

        for (int i = 0; i < 40; i++) begin
            word   = (36'h1_0204_0811 * (i + 1)) ^ {i[3:0], 32'h0} ^ {4'h0, 32'(i * 7)};
            fifo_q = ~word ^ 36'h0_00FF_00FF;
            // R7: held write request, counted in writer edges
            @(negedge wr_clk);
            wr_en = 1'b1; wr_data = word;
            n = 0;
            forever begin
                @(posedge wr_clk); #2; n++;
                if (!mail_n || n >= 6) break;
            end
            wr_en = 1'b0;
            check("R2 flag low after write", {35'd0, mail_n}, 36'd0);
            if (i == 0) check("R7 idle write edges", 36'(n), 36'd1);
            else        check("R7 write within three edges", 36'(n <= 3), 36'd1);

            // R4: read before the word is visible to the reader
            rd_en = 1'b1; rd_sel_mbx = 1'b1;
            @(posedge rd_clk); #1 rd_en = 1'b0;
            check("R4 early read ignored", {35'd0, mail_n}, 36'd0);

            // R3: overwrite attempt while pending
            @(negedge wr_clk);
            wr_en = 1'b1; wr_data = ~word;
            @(posedge wr_clk); #2 wr_en = 1'b0;
            rd_sel_mbx = 1'b1; #1;
            check("R3 word kept", rd_data, word);
            check("R3 flag kept", {35'd0, mail_n}, 36'd0);

            rd_pulse(1'b1, 1'b0, 2);
            check("R6 fifo while pending", rd_data, fifo_q);
            check("R4 fifo read keeps flag", {35'd0, mail_n}, 36'd0);
            rd_pulse(1'b0, 1'b1, 3);
            check("R1 word visible", rd_data, word);
            check("R4 no strobe keeps flag", {35'd0, mail_n}, 36'd0);

            rd_pulse(1'b1, 1'b1, 1);
            check("R4 clear raises flag", {35'd0, mail_n}, 36'd1);
            check("R7 word until clear", rd_data, word);
        end
        repeat (4) @(posedge rd_clk);
        #1 check("R4 flag stays high", {35'd0, mail_n}, 36'd1);
        finish_run();
    end
endmodule